// File: doc/BRIEF.md
# Prioritized Multi-Channel Interrupt Controller

This block gathers interrupt requests from a set of peripheral channels and from two non-maskable sources: an external pin and a watchdog. Each source has a request flag that captures a rising edge on its input. Every peripheral channel carries a 3-bit priority level. The block picks the single most urgent pending source and presents its vector and level to the CPU. It presents that source only when its level reaches the mask level the CPU supplies. When the CPU accepts the request, the block clears that source's flag and returns the mask level the CPU should adopt next.

A small bank of start-vector slots can redirect a channel to a DMA engine. A pending, enabled channel whose vector is held in a slot raises that slot's DMA request instead of competing for the CPU. The DMA engine then clears the flag through a per-slot take or burst-end strobe. Software configures priorities and slots, reads flag state back and clears flags through a byte-wide register bus.

Top module: `irqc_top`

## Requirements
- R1: After reset all flags, priorities and DMA slots are zero, and `irq_valid`, `dma_req` and `ack_mask` are 0. A rising edge on any request input sets that source's flag at the next clock edge.
- R2: A channel competes only when its priority is 1 to 6. Levels 0 and 7 disable it, but its flag still latches and reads back.
- R3: Source vectors are fixed. The non-maskable pin has vector 1 and the watchdog vector 2, and both always request at level 7. Channel i has vector i+3.
- R4: Among the competing sources the highest level is chosen. Among equal levels the lowest vector is chosen.
- R5: `irq_valid` is asserted only if the chosen level is greater than or equal to `cpu_mask`. The vector, level and valid outputs are registered and reflect the previous cycle's flags and mask.
- R6: When `cpu_ack` is high while `irq_valid` is high, the flag of the presented vector clears. In the next cycle `irq_valid` is 0 and `ack_mask` equals the presented level plus 1, saturating at 7.
- R7: Priority register k is at address k. It holds channel 2k in bits 2:0 with its flag at bit 3, and channel 2k+1 in bits 6:4 with its flag at bit 7. A write loads both priority fields. Writing 0 to a flag bit clears that flag, and writing 1 there has no effect.
- R8: DMA slot k is at address NPR+k, where NPR = ceil(N_CH/2), and it holds a vector in its low bits. The value 0 marks the slot as unused, so it matches no channel.
- R9: A pending, enabled channel whose vector is held in slot k asserts `dma_req[k]` from the next cycle. That channel is excluded from CPU selection.
- R10: A pulse on `dma_ack[k]` or on `dma_done[k]` clears the flag of the channel whose vector is held in slot k.
- R11: A request edge in the same cycle as any clear of that flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | N_CH | Peripheral request lines, edge detected |
| nmi_in | input | 1 | Non-maskable pin request, edge detected |
| wdt_in | input | 1 | Watchdog request, edge detected |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cpu_mask | input | 3 | Current CPU mask level |
| cpu_ack | input | 1 | CPU accepts the presented request |
| irq_valid | output | 1 | A request qualifies for the CPU |
| irq_vector | output | VEC_W | Vector of the presented request |
| irq_level | output | 3 | Level of the presented request |
| ack_mask | output | 3 | Mask level to adopt after the last acceptance |
| dma_req | output | N_DMA | Per-slot DMA request |
| dma_ack | input | N_DMA | Per-slot strobe: request taken by DMA |
| dma_done | input | N_DMA | Per-slot strobe: DMA burst ended |

## Verification
The bench builds the controller with N_CH=7 and N_DMA=2. The odd channel count leaves the upper nibble of the last priority register without a channel behind it, and it makes the vector field four bits wide. Seven channels are enough to reach ties at a shared level, both disabled codes, a level below the mask and a level exactly at the mask. With two slots the bench can divert one channel through a take strobe and another through a burst-end strobe in the same run.

// File: rtl/irqc_pkg.sv
// Shared types and helpers for the interrupt controller.
// Assumes 3-bit levels where 0 and 7 are not usable for maskable channels.
package irqc_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_TOP = 3'd7;

    // A channel level competes only in the range 1..6
    function automatic logic lvl_enabled(input lvl_t p);
        return (p != 3'd0) && (p != LVL_TOP);
    endfunction

    // Mask level the CPU adopts after accepting a request of level p
    function automatic lvl_t next_mask(input lvl_t p);
        return (p == LVL_TOP) ? LVL_TOP : lvl_t'(p + 3'd1);
    endfunction
endpackage

// File: rtl/irqc_flag_bank.sv
// Request flag array: one flag per source, set by a rising input edge,
// cleared by a per-source clear strobe. Set has priority over clear.
// Assumes request inputs are already synchronous to clk.
module irqc_flag_bank #(
    parameter int NSRC = 38
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] flags
);
    logic [NSRC-1:0] req_prev;

    // Edge history and flag state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_prev <= '0;
            flags    <= '0;
        end else begin
            req_prev <= req;
            flags    <= (req & ~req_prev) | (flags & ~clr);
        end
    end
endmodule

// File: rtl/irqc_cfg_regs.sv
// Byte-wide register bank: channel priority pairs, then DMA start-vector
// slots. Reads are combinational. Writing 0 to a flag bit yields a one-cycle
// clear strobe for that channel. Assumes VEC_W <= 8.
module irqc_cfg_regs
    import irqc_pkg::*;
#(
    parameter int N_CH   = 36,
    parameter int N_DMA  = 4,
    parameter int VEC_W  = 6,
    parameter int ADDR_W = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_wr,
    input  logic [7:0]                   bus_wdata,
    output logic [7:0]                   bus_rdata,
    input  logic [N_CH-1:0]              ch_flags,
    output logic [N_CH-1:0][LVL_W-1:0]   prio,
    output logic [N_DMA-1:0][VEC_W-1:0]  dma_vec,
    output logic [N_CH-1:0]              sw_clr
);
    localparam int NPR = (N_CH + 1) / 2;

    // Register writes for priority fields and DMA slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio    <= '0;
            dma_vec <= '0;
        end else if (bus_wr) begin
            for (int i = 0; i < N_CH; i++) begin
                if (int'(bus_addr) == i / 2)
                    prio[i] <= bus_wdata[4*(i%2) +: LVL_W];
            end
            for (int k = 0; k < N_DMA; k++) begin
                if (int'(bus_addr) == NPR + k)
                    dma_vec[k] <= bus_wdata[VEC_W-1:0];
            end
        end
    end

    // Software clear strobes from zero flag bits in a write
    always_comb begin
        sw_clr = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (bus_wr && (int'(bus_addr) == i / 2) && !bus_wdata[4*(i%2) + 3])
                sw_clr[i] = 1'b1;
        end
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (int'(bus_addr) == i / 2)
                bus_rdata[4*(i%2) +: 4] = {ch_flags[i], prio[i]};
        end
        for (int k = 0; k < N_DMA; k++) begin
            if (int'(bus_addr) == NPR + k)
                bus_rdata = 8'(dma_vec[k]);
        end
    end
endmodule

// File: rtl/irqc_select.sv
// Combinational arbiter. Source 0 is the non-maskable pin and source 1 the
// watchdog, both at level 7; source s has vector s+1. Channels held in a
// DMA slot are diverted away from CPU selection. Highest level wins, and on
// equal levels the lowest vector wins.
module irqc_select
    import irqc_pkg::*;
#(
    parameter int N_CH  = 36,
    parameter int N_DMA = 4,
    parameter int VEC_W = 6
) (
    input  logic [N_CH+1:0]              flags,
    input  logic [N_CH-1:0][LVL_W-1:0]   prio,
    input  logic [N_DMA-1:0][VEC_W-1:0]  dma_vec,
    output logic                         cand_any,
    output logic [VEC_W-1:0]             best_vec,
    output lvl_t                         best_lvl,
    output logic [N_DMA-1:0]             dma_hit,
    output logic [N_DMA-1:0][N_CH-1:0]   slot_match
);
    localparam int NSRC = N_CH + 2;

    logic [N_CH-1:0] divert;
    logic [NSRC-1:0] src_cand;
    lvl_t            src_lvl [NSRC];

    // Slot-to-channel vector match; slot value 0 matches nothing
    for (genvar k = 0; k < N_DMA; k++) begin : g_slot
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            assign slot_match[k][i] = (dma_vec[k] != '0) &&
                                      (dma_vec[k] == VEC_W'(i + 3));
        end
    end

    // Diversion of enabled channels and per-slot DMA request
    always_comb begin
        divert  = '0;
        dma_hit = '0;
        for (int k = 0; k < N_DMA; k++) begin
            for (int i = 0; i < N_CH; i++) begin
                if (slot_match[k][i] && lvl_enabled(prio[i])) begin
                    divert[i] = 1'b1;
                    if (flags[i+2]) dma_hit[k] = 1'b1;
                end
            end
        end
    end

    // Per-source level and candidacy
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        if (s < 2) begin : g_nm
            assign src_lvl[s]  = LVL_TOP;
            assign src_cand[s] = flags[s];
        end else begin : g_mk
            assign src_lvl[s]  = prio[s-2];
            assign src_cand[s] = flags[s] && lvl_enabled(prio[s-2]) && !divert[s-2];
        end
    end

    // Winner scan in ascending vector order; strict compare keeps the lowest vector
    always_comb begin
        int best_idx;
        cand_any = 1'b0;
        best_lvl = '0;
        best_idx = 0;
        for (int s = 0; s < NSRC; s++) begin
            if (src_cand[s] && (!cand_any || (src_lvl[s] > best_lvl))) begin
                cand_any = 1'b1;
                best_lvl = src_lvl[s];
                best_idx = s;
            end
        end
        best_vec = VEC_W'(best_idx + 1);
    end
endmodule

// File: rtl/irqc_top.sv
// Prioritized interrupt controller top. It combines the flag bank, the
// register bank and the arbiter, and registers the CPU-facing request, the
// mask level returned on acceptance and the DMA requests. Assumes a single
// clock, synchronous inputs, and a CPU that acknowledges only the request
// currently presented.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N_CH  = 36,
    parameter int N_DMA = 4,
    localparam int NSRC   = N_CH + 2,
    localparam int VEC_W  = $clog2(N_CH + 3),
    localparam int NPR    = (N_CH + 1) / 2,
    localparam int ADDR_W = $clog2(NPR + N_DMA)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   req_in,
    input  logic              nmi_in,
    input  logic              wdt_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [2:0]        cpu_mask,
    input  logic              cpu_ack,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector,
    output logic [2:0]        irq_level,
    output logic [2:0]        ack_mask,
    output logic [N_DMA-1:0]  dma_req,
    input  logic [N_DMA-1:0]  dma_ack,
    input  logic [N_DMA-1:0]  dma_done
);
    logic [NSRC-1:0]               src_req;
    logic [NSRC-1:0]               src_clr;
    logic [NSRC-1:0]               src_flags;
    logic [N_CH-1:0][LVL_W-1:0]    prio;
    logic [N_DMA-1:0][VEC_W-1:0]   dma_vec;
    logic [N_CH-1:0]               sw_clr;
    logic                          cand_any;
    logic [VEC_W-1:0]              best_vec;
    lvl_t                          best_lvl;
    logic [N_DMA-1:0]              dma_hit;
    logic [N_DMA-1:0][N_CH-1:0]    slot_match;
    logic                          take;

    assign src_req = {req_in, wdt_in, nmi_in};
    assign take    = cpu_ack && irq_valid;

    irqc_flag_bank #(.NSRC(NSRC)) flags_i (
        .clk(clk), .rst_n(rst_n), .req(src_req), .clr(src_clr), .flags(src_flags)
    );

    irqc_cfg_regs #(.N_CH(N_CH), .N_DMA(N_DMA), .VEC_W(VEC_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_flags(src_flags[NSRC-1:2]),
        .prio(prio), .dma_vec(dma_vec), .sw_clr(sw_clr)
    );

    irqc_select #(.N_CH(N_CH), .N_DMA(N_DMA), .VEC_W(VEC_W)) sel_i (
        .flags(src_flags), .prio(prio), .dma_vec(dma_vec), .cand_any(cand_any),
        .best_vec(best_vec), .best_lvl(best_lvl), .dma_hit(dma_hit), .slot_match(slot_match)
    );

    // Gather clear strobes: CPU acceptance, software, DMA take and burst end
    always_comb begin
        src_clr = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (take && (irq_vector == VEC_W'(s + 1))) src_clr[s] = 1'b1;
        end
        for (int i = 0; i < N_CH; i++) begin
            if (sw_clr[i]) src_clr[i+2] = 1'b1;
            for (int k = 0; k < N_DMA; k++) begin
                if ((dma_ack[k] || dma_done[k]) && slot_match[k][i]) src_clr[i+2] = 1'b1;
            end
        end
    end

    // Registered CPU request, returned mask level and DMA requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
            irq_level  <= '0;
            ack_mask   <= '0;
            dma_req    <= '0;
        end else begin
            irq_valid  <= cand_any && (best_lvl >= cpu_mask) && !take;
            irq_vector <= best_vec;
            irq_level  <= best_lvl;
            dma_req    <= dma_hit;
            if (take) ack_mask <= next_mask(irq_level);
        end
    end
endmodule

// File: rtl/irqc_chk.sv
// Property checker for irqc_top, attached by bind. It watches the ports and
// the flag vector between the flag bank and the arbiter.
module irqc_chk #(
    parameter int NSRC  = 38,
    parameter int VEC_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  src_req,
    input logic [NSRC-1:0]  src_flags,
    input logic [2:0]       cpu_mask,
    input logic             cpu_ack,
    input logic             irq_valid,
    input logic [VEC_W-1:0] irq_vector,
    input logic [2:0]       irq_level,
    input logic [2:0]       ack_mask
);
    // R5
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_level >= $past(cpu_mask)));

    // R2
    level_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_level != 3'd0));

    // R6
    ack_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && irq_valid) |=> !irq_valid);

    // R6
    ack_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && irq_valid) |=>
            (ack_mask == (($past(irq_level) == 3'd7) ? 3'd7 : 3'($past(irq_level) + 3'd1))));

    // R11
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(src_req) & ~$past(src_req, 2)) & ~src_flags) == '0));

    // R3
    nmi_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && $past(src_flags[0])) |-> ((irq_vector == VEC_W'(1)) && (irq_level == 3'd7)));
endmodule

bind irqc_top irqc_chk #(.NSRC(NSRC), .VEC_W(VEC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_flags(src_flags),
    .cpu_mask(cpu_mask), .cpu_ack(cpu_ack), .irq_valid(irq_valid),
    .irq_vector(irq_vector), .irq_level(irq_level), .ack_mask(ack_mask)
);

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
    localparam int N_CH  = 7;
    localparam int N_DMA = 2;
    localparam int VEC_W = 4;
    localparam int AW    = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_CH-1:0]  req_in = '0;
    logic             nmi_in = 1'b0, wdt_in = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic             bus_wr = 1'b0;
    logic [7:0]       bus_wdata = '0;
    logic [7:0]       bus_rdata;
    logic [2:0]       cpu_mask = '0;
    logic             cpu_ack = 1'b0;
    logic             irq_valid;
    logic [VEC_W-1:0] irq_vector;
    logic [2:0]       irq_level, ack_mask;
    logic [N_DMA-1:0] dma_req;
    logic [N_DMA-1:0] dma_ack = '0, dma_done = '0;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    irqc_top #(.N_CH(N_CH), .N_DMA(N_DMA)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .nmi_in(nmi_in), .wdt_in(wdt_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_mask(cpu_mask), .cpu_ack(cpu_ack), .irq_valid(irq_valid),
        .irq_vector(irq_vector), .irq_level(irq_level), .ack_mask(ack_mask),
        .dma_req(dma_req), .dma_ack(dma_ack), .dma_done(dma_done)
    );

    // Priority bytes with flag bits 0: ch0=3 ch1=5 ch2=5 ch3=0 ch4=7 ch5=6 ch6=1
    localparam logic [7:0] PRIO_BYTES [4] = '{8'h53, 8'h05, 8'h67, 8'h01};

    // Vector table: {req[6:0], mask[2:0], valid, vector[3:0], level[2:0]}
    localparam logic [17:0] TBL [8] = '{
        {7'b0000001, 3'd0, 1'b1, 4'd3, 3'd3},
        {7'b0000110, 3'd0, 1'b1, 4'd4, 3'd5},
        {7'b0100111, 3'd0, 1'b1, 4'd8, 3'd6},
        {7'b0011000, 3'd0, 1'b0, 4'd0, 3'd0},
        {7'b1000000, 3'd2, 1'b0, 4'd0, 3'd0},
        {7'b1000000, 3'd1, 1'b1, 4'd9, 3'd1},
        {7'b0000011, 3'd5, 1'b1, 4'd4, 3'd5},
        {7'b0000001, 3'd4, 1'b0, 4'd0, 3'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [N_CH-1:0] r, input logic n, input logic w);
        @(negedge clk);
        req_in = r; nmi_in = n; wdt_in = w;
        @(negedge clk);
        req_in = '0; nmi_in = 1'b0; wdt_in = 1'b0;
        cyc(2);
    endtask

    task automatic clear_all();
        for (int r = 0; r < 4; r++) wr(AW'(r), PRIO_BYTES[r]);
        cyc(2);
    endtask

    task automatic accept();
        @(negedge clk);
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
    endtask

    initial begin
        #1_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 irq_valid after reset", irq_valid, 0);
        chk("R1 dma_req after reset", dma_req, 0);
        chk("R1 ack_mask after reset", ack_mask, 0);
        rd(0, d); chk("R1 reg0 after reset", d, 8'h00);

        for (int r = 0; r < 4; r++) wr(AW'(r), PRIO_BYTES[r]);
        rd(2, d); chk("R7 reg2 readback", d, 8'h67);

        // R4 R5 R2 R8 table walk
        for (int t = 0; t < 8; t++) begin
            clear_all();
            cpu_mask = TBL[t][10:8];
            pulse(TBL[t][17:11], 1'b0, 1'b0);
            chk($sformatf("R5 valid entry %0d", t), irq_valid, TBL[t][7]);
            if (TBL[t][7]) begin
                chk($sformatf("R4 vector entry %0d", t), irq_vector, TBL[t][6:3]);
                chk($sformatf("R4 level entry %0d", t), irq_level, TBL[t][2:0]);
            end
            chk($sformatf("R8 unused slots entry %0d", t), dma_req, 0);
        end
        cpu_mask = 3'd0;

        // R2 disabled channels still latch
        clear_all();
        pulse(7'b0011000, 1'b0, 1'b0);
        rd(1, d); chk("R2 ch3 flag readback", d, 8'h85);
        rd(2, d); chk("R2 ch4 flag readback", d, 8'h6F);

        // R7 selective software clear
        clear_all();
        pulse(7'b0000011, 1'b0, 1'b0);
        rd(0, d); chk("R7 both flags", d, 8'hDB);
        wr(0, 8'hD3);
        cyc(2);
        rd(0, d); chk("R7 ch0 cleared ch1 kept", d, 8'hD3);
        chk("R7 remaining vector", irq_vector, 4);

        // R11 set wins over clear
        clear_all();
        pulse(7'b0000001, 1'b0, 1'b0);
        @(negedge clk);
        bus_addr = 0; bus_wdata = 8'h53; bus_wr = 1'b1; req_in = 7'b0000001;
        @(negedge clk);
        bus_wr = 1'b0; req_in = '0;
        rd(0, d); chk("R11 flag kept", d, 8'h5B);

        // R6 acceptance
        clear_all();
        pulse(7'b0100001, 1'b0, 1'b0);
        chk("R6 first vector", irq_vector, 8);
        accept();
        chk("R6 bubble", irq_valid, 0);
        chk("R6 ack_mask level6", ack_mask, 7);
        cyc(1);
        chk("R6 next valid", irq_valid, 1);
        chk("R6 next vector", irq_vector, 3);
        accept();
        chk("R6 ack_mask level3", ack_mask, 4);
        cyc(1);
        chk("R6 none left", irq_valid, 0);

        // R3 non-maskable sources
        clear_all();
        cpu_mask = 3'd7;
        pulse(7'b0100000, 1'b1, 1'b1);
        chk("R3 nmi valid", irq_valid, 1);
        chk("R3 nmi vector", irq_vector, 1);
        chk("R3 nmi level", irq_level, 7);
        accept();
        chk("R6 ack_mask saturates", ack_mask, 7);
        cyc(1);
        chk("R3 wdt vector", irq_vector, 2);
        chk("R3 wdt level", irq_level, 7);
        accept();
        cyc(1);
        chk("R5 level6 below mask7", irq_valid, 0);
        cpu_mask = 3'd0;
        cyc(2);
        chk("R5 level6 at mask0", irq_vector, 8);

        // R9 R10 DMA diversion
        clear_all();
        wr(3'd4, 8'd5);
        rd(3'd4, d); chk("R8 slot0 readback", d, 8'd5);
        pulse(7'b0000101, 1'b0, 1'b0);
        chk("R9 slot0 request", dma_req, 2'b01);
        chk("R9 diverted ch2 skipped", irq_vector, 3);
        chk("R9 lower level to cpu", irq_level, 3);
        @(negedge clk); dma_ack = 2'b01;
        @(negedge clk); dma_ack = 2'b00;
        cyc(1);
        chk("R10 dma_ack drops request", dma_req, 0);
        rd(1, d); chk("R10 ch2 flag cleared", d, 8'h05);
        wr(3'd5, 8'd3);
        cyc(2);
        chk("R9 slot1 request", dma_req, 2'b10);
        chk("R9 cpu sees nothing", irq_valid, 0);
        @(negedge clk); dma_done = 2'b10;
        @(negedge clk); dma_done = 2'b00;
        cyc(1);
        chk("R10 dma_done drops request", dma_req, 0);
        rd(0, d); chk("R10 ch0 flag cleared", d, 8'h53);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule